// File: doc/BRIEF.md
# Pattern-Fetch Address Remap with Nametable Mirroring

This block is the picture-side half of a cartridge address controller. It drives two pattern-memory address lines (bits 3 and 12) and the nametable RAM bit-10 line from the graphics processor's address bus. Three control bits decide how it does this. They are held in the CPU-side register block and arrive here as plain inputs.

In the one-bit-per-pixel display mode, the block replaces the pattern address with bits it saved from the preceding nametable fetch. It watches address line 13. When that line rises, a fetch outside the pattern area has started, and the block captures address bits 0 and 9. Every later pattern fetch (line 13 low) then uses the captured bit 0 as pattern address bit 3 and the captured bit 9 as pattern address bit 12. This lets the nametable byte position select the tile row and the pattern half.

The nametable line implements vertical or horizontal mirroring. Mirroring is forced to vertical unless a mirroring-enable bit allows the select bit to act. Line 13 is sampled on the system clock, which must run much faster than the graphics address bus changes.

Top module: `ppu_1bpp_remap`

## Requirements
- R1: With `cfg_1bpp` = 0, `chr_a3` equals `ppu_a3` and `chr_a12` equals `ppu_a12`, whatever the latch holds.
- R2: With `cfg_1bpp` = 1 and `ppu_a13` = 0, `chr_a3` equals the captured bit 0 and `chr_a12` equals the captured bit 9, not the live lines.
- R3: A capture happens at the first clock edge that samples `ppu_a13` high after it was sampled low, taking the live `ppu_a0` and `ppu_a9` at that edge. Changes on those lines while `ppu_a13` stays high are ignored.
- R4: With `ppu_a13` = 1, `chr_a3` and `chr_a12` follow `ppu_a3` and `ppu_a12` even when `cfg_1bpp` = 1.
- R5: With `cfg_mir_en` = 1, `cfg_mir_vert` = 1 gives vertical mirroring (`ciram_a10` = `ppu_a10`) and `cfg_mir_vert` = 0 gives horizontal mirroring (`ciram_a10` = `ppu_a11`).
- R6: With `cfg_mir_en` = 0, `cfg_mir_vert` is ignored and `ciram_a10` = `ppu_a10`.
- R7: While `rst_n` is low, and until the internal reset has been released, the block behaves as if all control bits were 0: pass-through pattern lines and vertical mirroring.
- R8: Reset clears the captured bits to 0. A pattern fetch in the one-bit mode before any rise of `ppu_a13` drives 0 on both `chr_a3` and `chr_a12`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample address line 13 |
| rst_n | input | 1 | Asynchronous active-low reset |
| ppu_a0 | input | 1 | Graphics address bit 0 |
| ppu_a3 | input | 1 | Graphics address bit 3 |
| ppu_a9 | input | 1 | Graphics address bit 9 |
| ppu_a10 | input | 1 | Graphics address bit 10 |
| ppu_a11 | input | 1 | Graphics address bit 11 |
| ppu_a12 | input | 1 | Graphics address bit 12 |
| ppu_a13 | input | 1 | Graphics address bit 13 (high outside pattern area) |
| cfg_1bpp | input | 1 | One-bit-per-pixel mode enable |
| cfg_mir_en | input | 1 | Allows `cfg_mir_vert` to choose the mirroring |
| cfg_mir_vert | input | 1 | Mirroring select: 1 vertical, 0 horizontal |
| chr_a3 | output | 1 | Pattern memory address bit 3 |
| chr_a12 | output | 1 | Pattern memory address bit 12 |
| ciram_a10 | output | 1 | Nametable RAM address bit 10 |

## Verification
The address patterns are chosen so that the live bit differs from the bit that would be wrongly picked. Bit 3 differs from bit 0, bit 12 differs from bit 9, and bit 10 differs from bit 11. A wrong source select therefore always shows at the pins. Some captures change bits 0 and 9 while line 13 is held high. These separate an edge-triggered capture from a level-transparent one. Two successive captures with opposite bit values show that the latch is reloaded on every rise. A one-bit-mode fetch right after reset shows the cleared latch, and the reset-time vectors separate gated controls from raw ones.

// File: rtl/ppu_remap_pkg.sv
package ppu_remap_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic row_bit;   // captured address bit 0
    logic half_bit;  // captured address bit 9
  } nt_capture_t;

  typedef enum logic {
    MIR_HORIZ = 1'b0,
    MIR_VERT  = 1'b1
  } mirror_t;
endpackage

// File: rtl/ppu_rst_sync.sv
module ppu_rst_sync #(
  parameter int unsigned STAGES = ppu_remap_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/ppu_fetch_latch.sv
module ppu_fetch_latch
  import ppu_remap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        a13,
  input  logic        a0,
  input  logic        a9,
  output nt_capture_t held
);
  logic        a13_q;
  logic        rise;
  logic        cap_en;
  nt_capture_t held_d;

  always_comb begin
    rise   = a13 & ~a13_q;
    cap_en = rise;
    held_d = held;
    if (cap_en) begin
      held_d.row_bit  = a0;
      held_d.half_bit = a9;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a13_q <= 1'b0;
      held  <= '0;
    end else begin
      a13_q <= a13;
      if (cap_en) held <= held_d;
    end
  end

  // R3: contents move only on a sampled rise of line 13
  a_r3_hold_between_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !(a13 && !a13_q) |=> $stable(held));
  // R8: latch is empty when the internal reset lifts
  a_r8_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (held == '0));
endmodule

// File: rtl/ppu_chr_remap.sv
module ppu_chr_remap
  import ppu_remap_pkg::*;
(
  input  logic        mode_1bpp,
  input  logic        a13,
  input  logic        a3,
  input  logic        a12,
  input  nt_capture_t held,
  output logic        chr_a3,
  output logic        chr_a12
);
  logic use_held;

  always_comb begin
    use_held = mode_1bpp & ~a13;
    chr_a3   = use_held ? held.row_bit  : a3;
    chr_a12  = use_held ? held.half_bit : a12;
  end
endmodule

// File: rtl/ppu_nt_mirror.sv
module ppu_nt_mirror
  import ppu_remap_pkg::*;
(
  input  logic mir_en,
  input  logic mir_vert,
  input  logic a10,
  input  logic a11,
  output logic nt_a10
);
  mirror_t arrangement;

  always_comb begin
    arrangement = (mir_en && !mir_vert) ? MIR_HORIZ : MIR_VERT;
    nt_a10      = (arrangement == MIR_VERT) ? a10 : a11;
  end
endmodule

// File: rtl/ppu_1bpp_remap.sv
module ppu_1bpp_remap
  import ppu_remap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ppu_a0,
  input  logic ppu_a3,
  input  logic ppu_a9,
  input  logic ppu_a10,
  input  logic ppu_a11,
  input  logic ppu_a12,
  input  logic ppu_a13,
  input  logic cfg_1bpp,
  input  logic cfg_mir_en,
  input  logic cfg_mir_vert,
  output logic chr_a3,
  output logic chr_a12,
  output logic ciram_a10
);
  logic        rst_int_n;
  logic        mode_eff;
  logic        mir_en_eff;
  nt_capture_t held;

  ppu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  // controls count as cleared until the internal reset lifts
  always_comb begin
    mode_eff   = cfg_1bpp   & rst_int_n;
    mir_en_eff = cfg_mir_en & rst_int_n;
  end

  ppu_fetch_latch u_latch (
    .clk   (clk),
    .rst_n (rst_int_n),
    .a13   (ppu_a13),
    .a0    (ppu_a0),
    .a9    (ppu_a9),
    .held  (held)
  );

  ppu_chr_remap u_chr (
    .mode_1bpp (mode_eff),
    .a13       (ppu_a13),
    .a3        (ppu_a3),
    .a12       (ppu_a12),
    .held      (held),
    .chr_a3    (chr_a3),
    .chr_a12   (chr_a12)
  );

  ppu_nt_mirror u_nt (
    .mir_en   (mir_en_eff),
    .mir_vert (cfg_mir_vert),
    .a10      (ppu_a10),
    .a11      (ppu_a11),
    .nt_a10   (ciram_a10)
  );

  // R1: mode off is a straight pass
  a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfg_1bpp |-> (chr_a3 == ppu_a3 && chr_a12 == ppu_a12));
  // R4: outside pattern area the lines pass
  a_r4_high_a13_pass: assert property (@(posedge clk) disable iff (!rst_int_n)
    ppu_a13 |-> (chr_a3 == ppu_a3 && chr_a12 == ppu_a12));
  // R6: select bit ignored without enable
  a_r6_forced_vertical: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfg_mir_en |-> (ciram_a10 == ppu_a10));
  // R5: enabled horizontal takes bit 11
  a_r5_horizontal: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_mir_en && !cfg_mir_vert) |-> (ciram_a10 == ppu_a11));
endmodule

// File: tb/tb_ppu_1bpp_remap.sv
module tb_ppu_1bpp_remap;
  logic clk = 1'b0;
  logic rst_n;
  logic [13:0] addr;
  logic cfg_1bpp, cfg_mir_en, cfg_mir_vert;
  logic chr_a3, chr_a12, ciram_a10;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ppu_1bpp_remap dut (
    .clk(clk), .rst_n(rst_n),
    .ppu_a0(addr[0]), .ppu_a3(addr[3]), .ppu_a9(addr[9]),
    .ppu_a10(addr[10]), .ppu_a11(addr[11]), .ppu_a12(addr[12]),
    .ppu_a13(addr[13]),
    .cfg_1bpp(cfg_1bpp), .cfg_mir_en(cfg_mir_en), .cfg_mir_vert(cfg_mir_vert),
    .chr_a3(chr_a3), .chr_a12(chr_a12), .ciram_a10(ciram_a10)
  );

  // [19] 1bpp, [18] mir_en, [17] mir_vert, [16:3] address, [2:0] {a3,a12,a10}
  localparam logic [19:0] VEC [8] = '{
    {3'b000, 14'h0008, 3'b100},  // R1 R6
    {3'b010, 14'h0800, 3'b001},  // R5 horizontal
    {3'b011, 14'h0800, 3'b000},  // R5 vertical
    {3'b000, 14'h1C00, 3'b011},  // R1 R6
    {3'b010, 14'h1401, 3'b010},  // R5 horizontal
    {3'b111, 14'h2408, 3'b101},  // R4 R5
    {3'b100, 14'h3201, 3'b010},  // R4 R6
    {3'b001, 14'h0A09, 3'b100}   // R6 select ignored
  };

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if ({chr_a3, chr_a12, ciram_a10} !== exp) begin
      fails++;
      $display("FAIL %s: got {a3,a12,a10}=%b expected %b", req,
               {chr_a3, chr_a12, ciram_a10}, exp);
    end
  endtask

  task automatic apply(input logic m, input logic e, input logic v, input logic [13:0] a);
    @(negedge clk);
    cfg_1bpp = m; cfg_mir_en = e; cfg_mir_vert = v; addr = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_1bpp = 1'b1; cfg_mir_en = 1'b1; cfg_mir_vert = 1'b0;
    addr = 14'h0A08;
    repeat (3) @(posedge clk);
    #1;
    check("R7 controls inert in reset", 3'b100);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R8 cleared latch, R5 horizontal", 3'b001);

    for (int i = 0; i < 8; i++) begin
      apply(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:3]);
      check($sformatf("R1/R4/R5/R6 vector %0d", i), VEC[i][2:0]);
    end

    // capture A0=1 A9=0 on the rise
    apply(1'b1, 1'b0, 1'b0, 14'h0000);
    apply(1'b1, 1'b0, 1'b0, 14'h2001);
    check("R4 pass while a13 high", 3'b000);
    apply(1'b1, 1'b0, 1'b0, 14'h2200);  // change while high: ignored
    apply(1'b1, 1'b0, 1'b0, 14'h1200);
    check("R2 R3 held bits used", 3'b100);
    // second rise with opposite bits
    apply(1'b1, 1'b0, 1'b0, 14'h2200);
    apply(1'b1, 1'b0, 1'b0, 14'h0009);
    check("R2 R3 recapture", 3'b010);
    apply(1'b0, 1'b0, 1'b0, 14'h0009);
    check("R1 mode off live bits", 3'b100);
    apply(1'b0, 1'b0, 1'b1, 14'h0800);
    check("R6 forced vertical", 3'b000);

    // reset again: latch must clear
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    addr = 14'h1201;
    cfg_1bpp = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R8 latch cleared by reset", 3'b000);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule